// File: doc/BRIEF.md
# Synchronous Burst SRAM Core with Flow-Through Reads

This block is a synthesizable model of a synchronous static RAM built around a small parameterized array. The address, the control pins and the write data are all captured on the rising clock edge. Read data takes a combinational path from the array to the outputs, with no output register. A word is therefore visible in the same cycle that its address is captured.

A two-bit beat counter runs beside a latched start address. Either of two address strobes loads that start address. The processor-side strobe always starts a read. The controller-side strobe also samples the write controls in the same cycle. An active-low step input then walks the low two address bits through a four-beat burst. A mode pin chooses whether the burst counts up by one each beat or XORs the beat number into the start bits.

Writes can use a global write, which stores every lane, or a byte-write enable that qualifies per-lane selects. The bench observes the output-drive decision on `q_oe`. A sleep input freezes all state, and nothing in the array is lost while it is asserted.

Top module: `burst_sram_core`

## Requirements
- R1: After reset is released, `q_oe` is 0 and `q` is all zeros until a selected strobe is captured.
- R2: On the edge that captures a selected strobe with `strobe_cpu_n`=0 or `strobe_ctl_n`=0, the internal address takes the value of `addr`. Once that edge has passed, in the same cycle, `q` shows the stored word at `addr` with `q_oe`=1, provided the cycle is a read.
- R3: With `order_lin`=1 at the load edge, beat k (k=0..3) reads from address {upper bits of start, (start[1:0]+k) mod 4}. Each `step_n`=0 edge advances one beat, and the upper bits never change during the burst.
- R4: With `order_lin`=0 at the load edge, beat k reads from address {upper bits of start, start[1:0] XOR k}.
- R5: A selected edge with `strobe_cpu_n`=0 starts a read even when the write controls request a write, and nothing is written. It takes priority over `strobe_ctl_n`.
- R6: A selected edge with `strobe_ctl_n`=0 and `all_wr_n`=0 writes `din` to every lane of the loaded address. The data is the value captured on that edge. The write commits on the next edge, so a read of the same address in the following cycle returns the new word.
- R7: When `all_wr_n`=1 and `lane_wr_en_n`=0, lane i (bits [i*LANE_W +: LANE_W]) is written exactly when `lane_sel_n[i]`=0. When `lane_wr_en_n`=1, no lane is written whatever the selects are, and the cycle is a read.
- R8: The chip is selected only when `en_n`=0, `cs_hi`=1 and `cs_lo_n`=0 at the strobe edge. A strobe captured while the chip is not selected loads nothing, writes nothing and leaves the core idle with `q_oe`=0.
- R9: `q_oe` is 0 and `q` is zero while `out_en_n`=1, while `sleep`=1, during a write cycle, and while the core is idle. `out_en_n` and `sleep` take effect without a clock edge.
- R10: While `sleep`=1, clock edges change neither the address, the cycle type nor the array. After `sleep` is released, the same word is shown again.
- R11: During an active burst, an edge with no strobe and `step_n`=1 keeps the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address captured at a load |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low, always a read |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low, samples write controls |
| step_n | input | 1 | Active-low burst advance |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| en_n | input | 1 | Active-low chip enable |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| all_wr_n | input | 1 | Active-low global write of every lane |
| lane_wr_en_n | input | 1 | Active-low enable that qualifies the lane selects |
| lane_sel_n | input | LANES | Active-low per-lane write selects |
| din | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous power-down, state frozen |
| q | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| q_oe | output | 1 | High when the read data bus would be driven |

## Verification
The bench builds the core with ADDR_W=5, LANES=4 and LANE_W=9, which gives a 32-word, 36-bit array. At that size it can write every word, then start a burst from all 32 start addresses in both orders and compare all four beats. It can also apply all sixteen lane-select patterns to one word. The same small array lets every sleep, deselect and output-enable case be followed by a read-back that proves the array and the address were untouched.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits for a given beat of a burst.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
    logic [1:0] res;
    if (linear) res = 2'(start + beat);
    else        res = start ^ beat;
    return res;
  endfunction

endpackage

// File: rtl/sram_addr_seq.sv
module sram_addr_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              lin_in,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic              lin_q,  lin_d;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    lin_d  = lin_q;
    if (load) begin
      base_d = addr_in;
      beat_d = 2'd0;
      lin_d  = lin_in;
    end else if (adv) begin
      beat_d = 2'(beat_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= 2'd0;
      lin_q  <= 1'b0;
    end else if (run) begin
      base_q <= base_d;
      beat_q <= beat_d;
      lin_q  <= lin_d;
    end
  end

  logic [HI_W-1:0] hi_bits;
  assign hi_bits  = base_q[ADDR_W-1:2];
  assign cur_addr = {hi_bits, beat_offset(base_q[1:0], beat_q, lin_q)};

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             chip_sel,
  input  logic             cpu_stb,
  input  logic             ctl_stb,
  input  logic             step_req,
  input  logic             all_wr,
  input  logic             lane_en,
  input  logic [LANES-1:0] lane_sel,
  output logic             load,
  output logic             adv,
  output op_e              op_q,
  output logic [LANES-1:0] mask_q
);

  op_e              op_d;
  logic [LANES-1:0] mask_d;
  logic             wr_req;

  always_comb begin
    if (all_wr)       mask_d = '1;
    else if (lane_en) mask_d = lane_sel;
    else              mask_d = '0;
    wr_req = |mask_d;
  end

  always_comb begin
    load = 1'b0;
    adv  = 1'b0;
    op_d = OP_IDLE;
    if (cpu_stb) begin
      load = chip_sel;
      op_d = chip_sel ? OP_READ : OP_IDLE;
    end else if (ctl_stb) begin
      load = chip_sel;
      if (chip_sel) op_d = wr_req ? OP_WRITE : OP_READ;
    end else if (op_q != OP_IDLE) begin
      adv  = step_req;
      op_d = wr_req ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      mask_q <= '0;
    end else if (run) begin
      op_q   <= op_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && mask[g]) bank[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[addr];
  end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    step_n,
  input  logic                    order_lin,
  input  logic                    en_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_oe
);

  localparam int DATA_W = LANES * LANE_W;

  // reset: asserted at once, released after two edges
  logic rs_a, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a       <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rs_a       <= 1'b1;
      rst_core_n <= rs_a;
    end
  end

  logic run, chip_sel, load, adv;
  op_e  op_q;
  logic [LANES-1:0]  mask_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wdata_q, wdata_d, rdata;

  assign run      = ~sleep;
  assign chip_sel = ~en_n & cs_hi & ~cs_lo_n;

  sram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .chip_sel (chip_sel),
    .cpu_stb  (~strobe_cpu_n),
    .ctl_stb  (~strobe_ctl_n),
    .step_req (~step_n),
    .all_wr   (~all_wr_n),
    .lane_en  (~lane_wr_en_n),
    .lane_sel (~lane_sel_n),
    .load     (load),
    .adv      (adv),
    .op_q     (op_q),
    .mask_q   (mask_q)
  );

  sram_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .load     (load),
    .adv      (adv),
    .addr_in  (addr),
    .lin_in   (order_lin),
    .cur_addr (cur_addr)
  );

  assign wdata_d = run ? din : wdata_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) wdata_q <= '0;
    else             wdata_q <= wdata_d;
  end

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .wr_en (run && (op_q == OP_WRITE)),
    .mask  (mask_q),
    .addr  (cur_addr),
    .wdata (wdata_q),
    .rdata (rdata)
  );

  assign q_oe = ~out_en_n & ~sleep & (op_q == OP_READ);
  assign q    = q_oe ? rdata : '0;

endmodule

// File: rtl/burst_sram_check.sv
module burst_sram_check
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              chip_sel,
  input logic              cpu_n,
  input logic              ctl_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr,
  input op_e               op,
  input logic              q_oe
);

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sleep) && $past(chip_sel) && (!$past(cpu_n) || !$past(ctl_n)))
      |-> cur_addr == $past(addr));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_n) && $past(ctl_n))
      |-> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

  assert_cpu_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sleep) && $past(chip_sel) && !$past(cpu_n)) |-> op == OP_READ);

  assert_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sleep) && !$past(chip_sel) && (!$past(cpu_n) || !$past(ctl_n)))
      |-> (op == OP_IDLE && !q_oe));

  assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |-> !q_oe);

  assert_sleep_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> (cur_addr == $past(cur_addr) && op == $past(op)));

endmodule

bind burst_sram_core burst_sram_check #(.ADDR_W(ADDR_W)) u_check (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .sleep    (sleep),
  .chip_sel (chip_sel),
  .cpu_n    (strobe_cpu_n),
  .ctl_n    (strobe_ctl_n),
  .addr     (addr),
  .cur_addr (cur_addr),
  .op       (op_q),
  .q_oe     (q_oe)
);

// File: tb/burst_sram_core_test.sv
module burst_sram_core_test;

  localparam int AW = 5;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int NW = 1 << AW;

  logic          clk, rst_n;
  logic [AW-1:0] addr;
  logic          strobe_cpu_n, strobe_ctl_n, step_n, order_lin;
  logic          en_n, cs_hi, cs_lo_n, all_wr_n, lane_wr_en_n;
  logic [LN-1:0] lane_sel_n;
  logic [DW-1:0] din, q;
  logic          out_en_n, sleep, q_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [DW-1:0] model [NW];

  burst_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_cpu_n(strobe_cpu_n),
    .strobe_ctl_n(strobe_ctl_n), .step_n(step_n), .order_lin(order_lin),
    .en_n(en_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .din(din),
    .out_en_n(out_en_n), .sleep(sleep), .q(q), .q_oe(q_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v;
    for (int i = 0; i < LN; i++) v[i*LW +: LW] = LW'(a*13 + i*71 + salt*29 + 5);
    return v;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    en_n = 0; cs_hi = 1; cs_lo_n = 0;
    all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = '1;
  endtask

  task automatic edge_settle();
    @(posedge clk); #1;
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] data,
                            input logic gw_n, input logic be_n, input logic [LN-1:0] sel_n,
                            input string req);
    logic [LN-1:0] m;
    logic [DW-1:0] e;
    m = !gw_n ? '1 : (!be_n ? ~sel_n : '0);
    e = model[a];
    for (int i = 0; i < LN; i++) if (m[i]) e[i*LW +: LW] = data[i*LW +: LW];
    @(negedge clk); idle();
    addr = AW'(a); strobe_ctl_n = 0; all_wr_n = gw_n; lane_wr_en_n = be_n;
    lane_sel_n = sel_n; din = data;
    edge_settle();
    if (m != 0) chk("R9 write cycle not driven", {35'b0, q_oe}, 0);
    else        chk("R7 no lane selected gives read", {35'b0, q_oe}, 1);
    model[a] = e;
    @(negedge clk); idle(); din = ~data;
    edge_settle();
    chk(req, q, model[a]);
  endtask

  task automatic read_burst(input int a, input logic lin, input logic wr_noise);
    int ea;
    @(negedge clk); idle();
    addr = AW'(a); strobe_cpu_n = 0; order_lin = lin;
    if (wr_noise) begin
      all_wr_n = 0; lane_wr_en_n = 0; lane_sel_n = '0; strobe_ctl_n = 0; din = '1;
    end
    edge_settle();
    chk("R2 beat0 driven", {35'b0, q_oe}, 1);
    chk(wr_noise ? "R5 cpu strobe reads" : "R2 beat0 data", q, model[a]);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); idle(); step_n = 0;
      edge_settle();
      ea = lin ? ((a & ~3) | ((a + k) & 3)) : ((a & ~3) | ((a & 3) ^ k));
      chk(lin ? "R3 linear beat" : "R4 interleaved beat", q, model[ea]);
    end
    @(negedge clk); idle();
  endtask

  task automatic load_read(input int a);
    @(negedge clk); idle(); addr = AW'(a); strobe_cpu_n = 0;
    edge_settle();
  endtask

  initial begin
    rst_n = 0; idle(); order_lin = 1; out_en_n = 0; sleep = 0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) edge_settle();
    chk("R1 reset not driven", {35'b0, q_oe}, 0);
    chk("R1 reset data zero", q, '0);

    for (int a = 0; a < NW; a++) write_word(a, pat(a, 0), 0, 1, '1, "R6 global write");

    for (int a = 0; a < NW; a++) begin
      read_burst(a, 1, a[0]);
      read_burst(a, 0, 1'b0);
    end

    for (int m = 0; m < 16; m++)
      write_word(3, pat(m, 7), 1, 0, ~LN'(m), "R7 lane-masked write");
    write_word(3, pat(1, 9), 1, 1, '0, "R7 lanes ignored without enable");

    // R8 deselect variants
    for (int v = 0; v < 3; v++) begin
      load_read(5);
      @(negedge clk); idle(); addr = 6; all_wr_n = 0; din = pat(6, 3);
      if (v == 0) begin en_n = 1; strobe_ctl_n = 0; end
      if (v == 1) begin cs_hi = 0; strobe_cpu_n = 0; end
      if (v == 2) begin cs_lo_n = 1; strobe_ctl_n = 0; end
      edge_settle();
      chk("R8 deselect not driven", {35'b0, q_oe}, 0);
      @(negedge clk); idle(); step_n = 0;
      edge_settle();
      chk("R8 stays idle", {35'b0, q_oe}, 0);
    end
    load_read(6);
    chk("R8 deselected write ignored", q, model[6]);

    // R9 asynchronous output enable
    load_read(7);
    out_en_n = 1; #1;
    chk("R9 oe high not driven", {35'b0, q_oe}, 0);
    chk("R9 oe high data zero", q, '0);
    out_en_n = 0; #1;
    chk("R9 oe low driven again", q, model[7]);

    // R10 sleep freeze
    load_read(9);
    sleep = 1; #1;
    chk("R9 sleep not driven", {35'b0, q_oe}, 0);
    @(negedge clk); idle(); addr = 20; strobe_ctl_n = 0; all_wr_n = 0; step_n = 0;
    din = pat(20, 5);
    repeat (3) @(posedge clk);
    @(negedge clk); idle(); sleep = 0; #1;
    chk("R10 address held over sleep", q, model[9]);
    load_read(20);
    chk("R10 no write during sleep", q, model[20]);

    // R11 hold
    load_read(12);
    repeat (2) begin
      @(negedge clk); idle();
      edge_settle();
      chk("R11 address held", q, model[12]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule